// File: doc/BRIEF.md
# Converter Register Slave on SPI

This block is the serial front end of a multi-channel data converter. A host talks to it over SPI mode 0. Each transaction opens with one instruction byte, and the instruction decides what follows. A write carries one data byte. A read returns one byte, or two bytes from consecutive addresses. The block holds the converter's control registers, a read-only identity byte and the 16-bit conversion result.

Writing the convert bit of the gain/channel register starts a conversion in a stub engine. The bit then reads back as busy for a fixed number of clock cycles. When the engine finishes, it captures a code from the `resultIn` port into the result registers.

The serial inputs are oversampled by the system clock through synchronizer stages. The serial clock must therefore run well below the system clock: each serial clock phase has to last several system clocks.

Top module: `cvtSpiRegs`

## Requirements
- R1: Bits are sent most significant bit first. The block samples `mosi` on rising `sclk` edges. In a read, the first data bit is on `miso` before the first rising edge that follows the instruction byte, and `miso` moves to the next bit only after a falling edge.
- R2: In the instruction byte, bit 6 = 1 selects a read and bit 6 = 0 selects a write. Bit 5 = 1 selects a two-byte read. Bits 4:0 hold the address. Bit 7 does not change the access.
- R3: A write has two bytes, and the data byte is stored at the addressed register. The registers at address 3 (A/D control), 5 (I/O state), 6 (I/O control) and 24 (serial control) read back all 8 bits as written.
- R4: Register 7 (oscillator control) keeps bits 5:0 as written. Its bits 7:6 read 0.
- R5: Writes to addresses 0, 1, 2 and 31 and to unmapped addresses are ignored. Address 2 reads 0, address 31 reads `ID_CODE`, and unmapped addresses read 0.
- R6: A two-byte read returns the addressed register first and the register at the next address second.
- R7: Register 4 holds the gain in bits 6:4, single-ended select in bit 3 and channel in bits 2:0, and these read back as written. Writing bit 7 = 1 while idle starts a conversion. Bit 7 then reads 1 for `CONV_CYCLES` clocks and 0 afterwards.
- R8: When a conversion ends, `resultIn[15:2]` is captured with bits 1:0 forced to 0. The low byte is then at address 0 and the high byte at address 1. The result changes at no other time.
- R9: Writing bit 7 = 1 while busy does not restart the running conversion. Bits 6:0 are still updated.
- R10: Raising `csN` in the middle of a transaction aborts it. A write without a complete data byte is not stored. The next transaction starts again with an instruction byte.
- R11: In a two-byte read at address 0, the high byte returned is the value it had when the low byte was loaded, even if a conversion ends between the two bytes.
- R12: `miso` is 0 while `csN` is high, during the instruction byte, and throughout a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| resultIn | input | 16 | Code captured at the end of a conversion |
| miso | output | 1 | Serial data to host |

## Verification
Two events can coincide: the end of a conversion can fall between the two bytes of a two-byte read of the result. The bench provokes this by starting a conversion, waiting a computed delay, and then issuing a two-byte read at address 0. With this timing the low byte loads before the conversion ends and the high byte loads after it. The bench judges the case by requiring the old high byte alongside the old low byte, and only the new code on the next read. A second overlap is a convert write that arrives while a conversion is still running. The bench checks this by reading the busy bit at a time when a restarted conversion would still show busy.

// File: rtl/cvtSpiPkg.sv
package cvtSpiPkg;

  localparam int ADDR_W = 5;
  localparam int RES_W  = 16;
  localparam int CODE_W = 14;

  localparam logic [ADDR_W-1:0] A_RESLO   = 5'd0;
  localparam logic [ADDR_W-1:0] A_RESHI   = 5'd1;
  localparam logic [ADDR_W-1:0] A_PGAOK   = 5'd2;
  localparam logic [ADDR_W-1:0] A_ADCTL   = 5'd3;
  localparam logic [ADDR_W-1:0] A_GAINMUX = 5'd4;
  localparam logic [ADDR_W-1:0] A_IOSTATE = 5'd5;
  localparam logic [ADDR_W-1:0] A_IOCTL   = 5'd6;
  localparam logic [ADDR_W-1:0] A_OSC     = 5'd7;
  localparam logic [ADDR_W-1:0] A_SERCTL  = 5'd24;
  localparam logic [ADDR_W-1:0] A_ID      = 5'd31;

  // instruction byte field positions
  localparam int INS_RD  = 6;
  localparam int INS_16  = 5;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  // strobes from serial control to the register datapath
  typedef struct packed {
    logic              wrEn;
    logic              loadTx;
    logic              shiftTx;
    logic              burst;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wrData;
  } spiStrobe_t;

endpackage

// File: rtl/cvtSpiCtrl.sv
module cvtSpiCtrl
  import cvtSpiPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output spiStrobe_t stb,
  output logic       txActive
);

  localparam int SW = SYNC_STAGES;

  logic [SW:0]   sclkPipe;
  logic [SW-1:0] csPipe;
  logic [SW-1:0] mosiPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SW-1:0], sclk};
      csPipe   <= {csPipe[SW-2:0], csN};
      mosiPipe <= {mosiPipe[SW-2:0], mosi};
    end
  end

  logic csAct, sclkRise, sclkFall, mosiBit;
  assign csAct    = ~csPipe[SW-1];
  assign sclkRise = sclkPipe[SW-1] & ~sclkPipe[SW];
  assign sclkFall = ~sclkPipe[SW-1] & sclkPipe[SW];
  assign mosiBit  = mosiPipe[SW-1];

  phase_t            phase;
  logic [2:0]        bitCnt;
  logic [6:0]        rxSh;
  logic [ADDR_W-1:0] curAddr;
  logic              is16;
  logic              firstByte;

  logic       byteDone;
  logic [7:0] rxByte;
  assign byteDone = csAct & sclkRise & (bitCnt == 3'd7);
  assign rxByte   = {rxSh, mosiBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      rxSh      <= '0;
      curAddr   <= '0;
      is16      <= 1'b0;
      firstByte <= 1'b0;
    end else if (!csAct) begin
      phase  <= PH_INSTR;
      bitCnt <= '0;
    end else if (sclkRise) begin
      rxSh   <= rxByte[6:0];
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        unique case (phase)
          PH_INSTR: begin
            curAddr   <= rxByte[ADDR_W-1:0];
            is16      <= rxByte[INS_16];
            firstByte <= 1'b1;
            phase     <= rxByte[INS_RD] ? PH_RDATA : PH_WDATA;
          end
          PH_RDATA: begin
            if (is16 && firstByte) begin
              firstByte <= 1'b0;
              curAddr   <= curAddr + 5'd1;
            end else begin
              phase <= PH_DONE;
            end
          end
          PH_WDATA: phase <= PH_DONE;
          default:  phase <= PH_DONE;
        endcase
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrData  = rxByte;
    stb.wrEn    = byteDone & (phase == PH_WDATA);
    stb.loadTx  = byteDone & (((phase == PH_INSTR) & rxByte[INS_RD]) |
                              ((phase == PH_RDATA) & is16 & firstByte));
    stb.burst   = (phase == PH_RDATA);
    stb.shiftTx = csAct & sclkFall & (phase == PH_RDATA) & (bitCnt != 3'd0);
    unique case (phase)
      PH_INSTR: stb.addr = rxByte[ADDR_W-1:0];
      PH_RDATA: stb.addr = curAddr + 5'd1;
      default:  stb.addr = curAddr;
    endcase
  end

  assign txActive = csAct & (phase == PH_RDATA);

endmodule

// File: rtl/cvtConvStub.sv
module cvtConvStub
  import cvtSpiPkg::*;
#(
  parameter int CONV_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convReq,
  input  logic [RES_W-1:0] resultIn,
  output logic             busy,
  output logic [RES_W-1:0] resultReg
);

  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);
  localparam logic [RES_W-1:0] CODE_MASK = {{CODE_W{1'b1}}, {(RES_W-CODE_W){1'b0}}};

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      resultReg <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy      <= 1'b0;
        cnt       <= '0;
        resultReg <= resultIn & CODE_MASK;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (convReq) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

endmodule

// File: rtl/cvtRegDatapath.sv
module cvtRegDatapath
  import cvtSpiPkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'h5A
) (
  input  logic             clk,
  input  logic             rstN,
  input  spiStrobe_t       stb,
  input  logic             txActive,
  input  logic             busy,
  input  logic [RES_W-1:0] resultReg,
  output logic             convReq,
  output logic             miso
);

  logic [7:0] adCtl, ioState, ioCtl, serCtl;
  logic [6:0] gmLow;
  logic [5:0] oscBits;
  logic [7:0] hiHold;
  logic [7:0] txSh;
  logic [7:0] rdByte;

  assign convReq = stb.wrEn & (stb.addr == A_GAINMUX) & stb.wrData[7];

  always_comb begin
    unique case (stb.addr)
      A_RESLO:   rdByte = resultReg[7:0];
      A_RESHI:   rdByte = stb.burst ? hiHold : resultReg[15:8];
      A_PGAOK:   rdByte = 8'h00;
      A_ADCTL:   rdByte = adCtl;
      A_GAINMUX: rdByte = {busy, gmLow};
      A_IOSTATE: rdByte = ioState;
      A_IOCTL:   rdByte = ioCtl;
      A_OSC:     rdByte = {2'b00, oscBits};
      A_SERCTL:  rdByte = serCtl;
      A_ID:      rdByte = ID_CODE;
      default:   rdByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adCtl   <= '0;
      gmLow   <= '0;
      ioState <= '0;
      ioCtl   <= '0;
      oscBits <= '0;
      serCtl  <= '0;
    end else if (stb.wrEn) begin
      unique case (stb.addr)
        A_ADCTL:   adCtl   <= stb.wrData;
        A_GAINMUX: gmLow   <= stb.wrData[6:0];
        A_IOSTATE: ioState <= stb.wrData;
        A_IOCTL:   ioCtl   <= stb.wrData;
        A_OSC:     oscBits <= stb.wrData[5:0];
        A_SERCTL:  serCtl  <= stb.wrData;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh   <= '0;
      hiHold <= '0;
    end else if (stb.loadTx) begin
      txSh <= rdByte;
      if (stb.addr == A_RESLO) hiHold <= resultReg[15:8];
    end else if (stb.shiftTx) begin
      txSh <= {txSh[6:0], 1'b0};
    end
  end

  assign miso = txActive & txSh[7];

endmodule

// File: rtl/cvtSpiRegs.sv
module cvtSpiRegs
  import cvtSpiPkg::*;
#(
  parameter int         CONV_CYCLES = 64,
  parameter logic [7:0] ID_CODE     = 8'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        mosi,
  input  logic [15:0] resultIn,
  output logic        miso
);

  spiStrobe_t       stb;
  logic             txActive;
  logic             convReq;
  logic             busy;
  logic [RES_W-1:0] resultReg;

  cvtSpiCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .stb(stb), .txActive(txActive)
  );

  cvtRegDatapath #(.ID_CODE(ID_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txActive(txActive),
    .busy(busy), .resultReg(resultReg), .convReq(convReq), .miso(miso)
  );

  cvtConvStub #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rstN(rstN), .convReq(convReq), .resultIn(resultIn),
    .busy(busy), .resultReg(resultReg)
  );

endmodule

// File: rtl/cvtSpiChk.sv
module cvtSpiChk #(
  parameter int CONV_CYCLES = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        miso,
  input logic        wrEn,
  input logic        busy,
  input logic [15:0] resultReg
);

  localparam int CW = $clog2(CONV_CYCLES + 2);

  logic [CW-1:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R12
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !miso);

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < CW'(CONV_CYCLES)));

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == CW'(CONV_CYCLES)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultReg) |-> $fell(busy));

  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

endmodule

bind cvtSpiRegs cvtSpiChk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso),
  .wrEn(stb.wrEn), .busy(busy), .resultReg(resultReg)
);

// File: tb/sim_cvtSpiRegs.sv
`timescale 1ns/1ps
module sim_cvtSpiRegs;

  localparam int         CONV = 400;
  localparam logic [7:0] IDV  = 8'hC7;
  localparam int         HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic [15:0] resultIn = 16'h0000;
  logic        miso;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  cvtSpiRegs #(.CONV_CYCLES(CONV), .ID_CODE(IDV)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .resultIn(resultIn), .miso(miso)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      mosi = tx[7-i];
      waitClk(HALF);
      rx[7-i] = miso;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2*HALF);
  endtask

  task automatic wrIns(input logic [7:0] ins, input logic [7:0] data);
    logic [7:0] r;
    csLow();
    spiBits(ins, 8, r);
    spiBits(data, 8, r);
    csHigh();
  endtask

  task automatic wr8(input logic [4:0] a, input logic [7:0] data);
    wrIns({3'b000, a}, data);
  endtask

  task automatic rdIns(input logic [7:0] ins, output logic [7:0] v);
    logic [7:0] r;
    csLow();
    spiBits(ins, 8, r);
    spiBits(8'h00, 8, v);
    csHigh();
  endtask

  task automatic rd8(input logic [4:0] a, output logic [7:0] v);
    rdIns({3'b010, a}, v);
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] v);
    logic [7:0] r, b0, b1;
    csLow();
    spiBits({3'b011, a}, 8, r);
    spiBits(8'h00, 8, b0);
    spiBits(8'h00, 8, b1);
    csHigh();
    v = {b1, b0};
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R12 miso after reset", {15'd0, miso}, 16'h0000);
    rd8(5'd31, v); check("R5 R1 id read", {8'h00, v}, {8'h00, IDV});
    rd8(5'd4, v);  check("R7 gainmux reset", {8'h00, v}, 16'h0000);
  endtask

  task automatic tRwRegs();
    logic [7:0] v;
    wr8(5'd3, 8'h5A);  rd8(5'd3, v);  check("R3 R1 adctl", {8'h00, v}, 16'h005A);
    wr8(5'd6, 8'hC3);  rd8(5'd6, v);  check("R3 ioctl", {8'h00, v}, 16'h00C3);
    wrIns(8'h85, 8'h7E); rd8(5'd5, v); check("R2 mode bit write", {8'h00, v}, 16'h007E);
    rdIns(8'hC5, v);   check("R2 mode bit read", {8'h00, v}, 16'h007E);
  endtask

  task automatic tOsc();
    logic [7:0] v;
    wr8(5'd7, 8'hFF); rd8(5'd7, v); check("R4 osc upper bits", {8'h00, v}, 16'h003F);
    wr8(5'd7, 8'h3C); rd8(5'd7, v); check("R4 osc readback", {8'h00, v}, 16'h003C);
  endtask

  task automatic tReadOnly();
    logic [7:0] v;
    wr8(5'd0, 8'hFF); wr8(5'd1, 8'hFF); wr8(5'd2, 8'hFF);
    wr8(5'd31, 8'h00); wr8(5'd9, 8'hFF);
    rd8(5'd0, v);  check("R5 result lo ro", {8'h00, v}, 16'h0000);
    rd8(5'd1, v);  check("R5 result hi ro", {8'h00, v}, 16'h0000);
    rd8(5'd2, v);  check("R5 pga valid", {8'h00, v}, 16'h0000);
    rd8(5'd31, v); check("R5 id ro", {8'h00, v}, {8'h00, IDV});
    rd8(5'd9, v);  check("R5 unmapped", {8'h00, v}, 16'h0000);
  endtask

  task automatic tIdleMiso();
    logic [7:0] r1, r2, v;
    csLow();
    spiBits(8'h18, 8, r1);
    spiBits(8'hA5, 8, r2);
    check("R12 miso in instr", {8'h00, r1}, 16'h0000);
    check("R12 miso in write", {8'h00, r2}, 16'h0000);
    csHigh();
    check("R12 miso cs high", {15'd0, miso}, 16'h0000);
    rd8(5'd24, v); check("R3 serctl", {8'h00, v}, 16'h00A5);
  endtask

  task automatic tConvert();
    logic [7:0]  v;
    logic [15:0] w;
    resultIn = 16'hABCF;
    wr8(5'd4, 8'h8B);
    rd8(5'd4, v); check("R7 busy reads 1", {8'h00, v}, 16'h008B);
    waitClk(CONV);
    rd8(5'd4, v); check("R7 busy cleared", {8'h00, v}, 16'h000B);
    rd16(5'd0, w); check("R8 R6 result", w, 16'hABCC);
  endtask

  task automatic tRestart();
    logic [7:0]  v;
    logic [15:0] w;
    resultIn = 16'h5555;
    wr8(5'd4, 8'h8B);
    wr8(5'd4, 8'h85);
    rd8(5'd4, v); check("R9 no restart", {8'h00, v}, 16'h0005);
    waitClk(CONV);
    rd16(5'd0, w); check("R8 result2", w, 16'h5554);
  endtask

  task automatic tCoherent();
    logic [15:0] w;
    resultIn = 16'h1237;
    wr8(5'd4, 8'h80);
    waitClk(200);
    rd16(5'd0, w); check("R11 coherent pair", w, 16'h5554);
    waitClk(CONV);
    rd16(5'd0, w); check("R11 R8 new pair", w, 16'h1234);
  endtask

  task automatic tAbort();
    logic [7:0] r, v;
    wr8(5'd3, 8'h3C);
    csLow();
    spiBits(8'h03, 8, r);
    spiBits(8'hFF, 5, r);
    csHigh();
    rd8(5'd3, v); check("R10 partial write", {8'h00, v}, 16'h003C);
    csLow();
    spiBits(8'h43, 4, r);
    csHigh();
    rd8(5'd3, v); check("R10 reframe", {8'h00, v}, 16'h003C);
  endtask

  task automatic tBurst();
    logic [15:0] w;
    wr8(5'd5, 8'h96);
    wr8(5'd6, 8'h69);
    rd16(5'd5, w); check("R6 burst order", w, 16'h6996);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    waitClk(10);
    rstN = 1'b1;
    waitClk(10);
    tReset();
    tRwRegs();
    tOsc();
    tReadOnly();
    tIdleMiso();
    tConvert();
    tRestart();
    tCoherent();
    tAbort();
    tBurst();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule